// File: doc/BRIEF.md
# Load Byte-Lane Alignment Network

This block sits between a word-aligned data cache and the register-file write port. A load presents its two low address bits, an access size and a sign flag in a request cycle. While the cache reads the whole 32-bit word, the block decodes these into one 2-bit select per output byte lane and holds the selects. When the cache word arrives, one level of 4-input byte multiplexers steers it to the register value. That value is registered and presented with a valid strobe one cycle later.

The four output lanes do not all offer the same choices. Lane 0 can take any of the four memory bytes. Lane 1 can take memory byte 1, memory byte 3, zero, or a sign fill. Lanes 2 and 3 can take their own memory byte, zero, or a sign fill. A sign fill is the top bit of the next lower output lane repeated eight times. This bit passes upward lane by lane, so a signed byte or halfword extends without any lane needing to know where the sign came from. A small controller with two states, ST_IDLE (no decoded request held) and ST_ARMED (selects held, waiting for the word), decides which cache beats produce a result.

The transitions are as follows. ST_IDLE moves to ST_ARMED on a request. ST_ARMED moves to ST_IDLE on a cache beat that has no new request. ST_ARMED stays in ST_ARMED on a new request, with or without a beat, and while it waits.

Top module: `load_lane_align`

## Requirements
- R1: After reset, load_valid and load_misaligned are 0.
- R2: With req_size code 2 (word) and offset 0, load_value equals mem_word unchanged.
- R3: With req_size code 0 (byte), load_value[7:0] is the memory byte at the request offset n. Byte ordering is little endian, so that byte is mem_word bits 8n+7..8n.
- R4: With req_signed = 0, every bit of load_value above the loaded byte or halfword is 0.
- R5: With req_signed = 1, every bit of load_value above the loaded byte or halfword equals that quantity's top bit.
- R6: With req_size code 1 (halfword), load_value[15:0] is mem_word[15:0] for offset 0 and mem_word[31:16] for offset 2.
- R7: load_misaligned is set with the result when the access is misaligned. An access is misaligned for a halfword with offset bit 0 set, for a word with a nonzero offset, or for the reserved size code 3. For such an access, load_value is unspecified.
- R8: A mem_valid beat that follows an accepted request gives load_valid high exactly one cycle later, with the aligned value.
- R9: A mem_valid beat with no request pending gives no load_valid.
- R10: A request in the same cycle as a beat does not affect that beat. The beat uses the earlier request's decode, and the new request serves the next beat.
- R11: A second request while one is pending and no beat has arrived replaces the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request; latches offset, size and sign |
| req_offset | input | 2 | Low two address bits of the load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | 1 selects sign extension, 0 selects zero extension |
| mem_valid | input | 1 | Cache word is present on mem_word |
| mem_word | input | 32 | Word read from the word-aligned cache |
| load_valid | output | 1 | load_value and load_misaligned are valid |
| load_value | output | 32 | Aligned and extended register value |
| load_misaligned | output | 1 | Access was misaligned; value unspecified |

## Verification
Two functions can fall in the same cycle. One is the select decode for a new request. The other is the data steering for the previous request's cache beat. The bench provokes this by raising req_valid together with mem_valid, using a second request that needs different lane selects. It then requires that the first result match the first request and that the next beat match the second. A further case stacks two requests with no beat between them, and only the later one may shape the result.

// File: rtl/lla_pkg.sv
package lla_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int SEL_W  = 2;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    // lane input codes for lanes 1..3
    localparam logic [SEL_W-1:0] PICK_OWN  = 2'd0;
    localparam logic [SEL_W-1:0] PICK_HIGH = 2'd1;  // lane 1 only: memory byte 3
    localparam logic [SEL_W-1:0] PICK_ZERO = 2'd2;
    localparam logic [SEL_W-1:0] PICK_FILL = 2'd3;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/lla_select_decode.sv
module lla_select_decode
    import lla_pkg::*;
(
    input  logic [OFF_W-1:0]            offset,
    input  logic [1:0]                  size,
    input  logic                        sign_ext,
    output logic [LANES-1:0][SEL_W-1:0] lane_sel,
    output logic                        misaligned
);
    logic [SEL_W-1:0] ext_code;

    always_comb begin
        ext_code   = sign_ext ? PICK_FILL : PICK_ZERO;
        lane_sel   = '0;
        misaligned = 1'b0;
        unique case (size_e'(size))
            SZ_BYTE: begin
                lane_sel[0] = offset;
                for (int k = 1; k < LANES; k++) lane_sel[k] = ext_code;
            end
            SZ_HALF: begin
                misaligned  = offset[0];
                lane_sel[0] = {offset[1], 1'b0};
                lane_sel[1] = offset[1] ? PICK_HIGH : PICK_OWN;
                for (int k = 2; k < LANES; k++) lane_sel[k] = ext_code;
            end
            SZ_WORD: begin
                misaligned = |offset;
                for (int k = 0; k < LANES; k++) lane_sel[k] = PICK_OWN;
            end
            SZ_RSVD: begin
                misaligned = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lla_lane_mux.sv
module lla_lane_mux
    import lla_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic [LANES-1:0][BYTE_W-1:0] mem_bytes,
    input  logic                         fill_bit,
    input  logic [SEL_W-1:0]             sel,
    output logic [BYTE_W-1:0]            lane_out
);
    logic [3:0][BYTE_W-1:0] choices;

    generate
        if (LANE == 0) begin : g_low
            always_comb begin
                for (int k = 0; k < 4; k++) choices[k] = mem_bytes[k];
            end
        end else if (LANE == 1) begin : g_second
            always_comb begin
                choices[PICK_OWN]  = mem_bytes[1];
                choices[PICK_HIGH] = mem_bytes[LANES-1];
                choices[PICK_ZERO] = '0;
                choices[PICK_FILL] = {BYTE_W{fill_bit}};
            end
        end else begin : g_upper
            always_comb begin
                choices[PICK_OWN]  = mem_bytes[LANE];
                choices[PICK_HIGH] = '0;
                choices[PICK_ZERO] = '0;
                choices[PICK_FILL] = {BYTE_W{fill_bit}};
            end
        end
    endgenerate

    assign lane_out = choices[sel];
endmodule

// File: rtl/lla_ctrl.sv
module lla_ctrl
    import lla_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic mem_valid,
    output logic armed,
    output logic fire
);
    ctrl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ARMED;
            ST_ARMED: if (mem_valid && !req_valid) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        armed = (state_q == ST_ARMED);
        fire  = armed && mem_valid;
    end
endmodule

// File: rtl/load_lane_align.sv
module load_lane_align
    import lla_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_word,
    output logic              load_valid,
    output logic [WORD_W-1:0] load_value,
    output logic              load_misaligned
);
    logic [LANES-1:0][SEL_W-1:0]  dec_sel;
    logic                         dec_mis;
    logic [LANES-1:0][SEL_W-1:0]  pend_sel;
    logic                         pend_mis;
    logic [1:0]                   pend_size;
    logic                         pend_signed;
    logic                         armed;
    logic                         fire;
    logic [LANES-1:0][BYTE_W-1:0] mem_bytes;
    logic [LANES-1:0][BYTE_W-1:0] lane_out;
    logic [LANES-1:0]             lane_fill;

    lla_select_decode u_dec (
        .offset     (req_offset),
        .size       (req_size),
        .sign_ext   (req_signed),
        .lane_sel   (dec_sel),
        .misaligned (dec_mis)
    );

    lla_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .mem_valid (mem_valid),
        .armed     (armed),
        .fire      (fire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_sel    <= '0;
            pend_mis    <= 1'b0;
            pend_size   <= 2'd0;
            pend_signed <= 1'b0;
        end else if (req_valid) begin
            pend_sel    <= dec_sel;
            pend_mis    <= dec_mis;
            pend_size   <= req_size;
            pend_signed <= req_signed;
        end
    end

    assign mem_bytes = mem_word;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            if (g == 0) begin : g_nofill
                assign lane_fill[g] = 1'b0;
            end else begin : g_chain
                assign lane_fill[g] = lane_out[g-1][BYTE_W-1];
            end
            lla_lane_mux #(.LANE(g)) u_mux (
                .mem_bytes (mem_bytes),
                .fill_bit  (lane_fill[g]),
                .sel       (pend_sel[g]),
                .lane_out  (lane_out[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_valid      <= 1'b0;
            load_value      <= '0;
            load_misaligned <= 1'b0;
        end else begin
            load_valid      <= fire;
            load_misaligned <= fire && pend_mis;
            if (fire) load_value <= lane_out;
        end
    end
endmodule

// File: rtl/lla_checker.sv
module lla_checker
    import lla_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic [WORD_W-1:0] mem_word,
    input logic              armed,
    input logic [1:0]        pend_size,
    input logic              pend_signed,
    input logic              load_valid,
    input logic [WORD_W-1:0] load_value,
    input logic              load_misaligned
);
    // R8: an armed beat yields a result next cycle
    a_r8_result_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mem_valid) |=> load_valid);

    // R9: no result without a beat on an armed controller
    a_r9_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> ($past(mem_valid) && $past(armed)));

    // R7: the flag only accompanies a result
    a_r7_flag_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        load_misaligned |-> load_valid);

    // R2: aligned word passes through
    a_r2_word_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && !load_misaligned && $past(pend_size) == 2'd2)
        |-> load_value == $past(mem_word));

    // R4: unsigned byte has zero upper bits
    a_r4_byte_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && $past(pend_size) == 2'd0 && !$past(pend_signed))
        |-> load_value[WORD_W-1:BYTE_W] == '0);

    // R5: signed byte replicates its top bit
    a_r5_byte_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && $past(pend_size) == 2'd0 && $past(pend_signed))
        |-> load_value[WORD_W-1:BYTE_W] == {(WORD_W-BYTE_W){load_value[BYTE_W-1]}});
endmodule

bind load_lane_align lla_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mem_valid       (mem_valid),
    .mem_word        (mem_word),
    .armed           (armed),
    .pend_size       (pend_size),
    .pend_signed     (pend_signed),
    .load_valid      (load_valid),
    .load_value      (load_value),
    .load_misaligned (load_misaligned)
);

// File: tb/load_lane_align_test.sv
module load_lane_align_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_offset;
    logic [1:0]  req_size;
    logic        req_signed;
    logic        mem_valid;
    logic [31:0] mem_word;
    logic        load_valid;
    logic [31:0] load_value;
    logic        load_misaligned;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    load_lane_align uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_offset(req_offset), .req_size(req_size),
        .req_signed(req_signed), .mem_valid(mem_valid), .mem_word(mem_word),
        .load_valid(load_valid), .load_value(load_value),
        .load_misaligned(load_misaligned)
    );

    function automatic logic [31:0] expect_value(input logic [1:0] sz, input logic [1:0] off,
                                                 input logic sg, input logic [31:0] w);
        logic [31:0] sh;
        sh = w >> (8 * off);
        case (sz)
            2'd0:    return sg ? {{24{sh[7]}}, sh[7:0]} : {24'd0, sh[7:0]};
            2'd1:    return sg ? {{16{sh[15]}}, sh[15:0]} : {16'd0, sh[15:0]};
            default: return w;
        endcase
    endfunction

    function automatic logic expect_mis(input logic [1:0] sz, input logic [1:0] off);
        return (sz == 2'd1 && off[0]) || (sz == 2'd2 && off != 2'd0) || (sz == 2'd3);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_req(input logic [1:0] sz, input logic [1:0] off, input logic sg);
        req_valid = 1'b1; req_size = sz; req_offset = off; req_signed = sg;
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; mem_valid = 1'b0;
    endtask

    task automatic check_result(input string req, input logic [1:0] sz, input logic [1:0] off,
                                input logic sg, input logic [31:0] w);
        logic m;
        m = expect_mis(sz, off);
        check({req, " R8 valid"}, {31'd0, load_valid}, 32'd1);
        check({req, " R7 flag"}, {31'd0, load_misaligned}, {31'd0, m});
        if (!m) begin
            if (sz == 2'd2)      check({req, " R2 word"}, load_value, expect_value(sz, off, sg, w));
            else if (sz == 2'd1) check({req, sg ? " R6 R5 half" : " R6 R4 half"}, load_value, expect_value(sz, off, sg, w));
            else                 check({req, sg ? " R3 R5 byte" : " R3 R4 byte"}, load_value, expect_value(sz, off, sg, w));
        end
    endtask

    task automatic one_load(input logic [1:0] sz, input logic [1:0] off, input logic sg,
                            input logic [31:0] w);
        @(negedge clk); drive_req(sz, off, sg); mem_valid = 1'b0;
        @(negedge clk); req_valid = 1'b0; mem_valid = 1'b1; mem_word = w;
        @(negedge clk); idle_inputs();
        check_result("sweep", sz, off, sg, w);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] words [4];
        words[0] = 32'h8A7F_01FE;
        words[1] = 32'h7E80_FF11;
        words[2] = 32'hF00D_8001;
        words[3] = 32'h1234_5678;

        rst_n = 1'b0; idle_inputs(); req_size = 2'd0; req_offset = 2'd0;
        req_signed = 1'b0; mem_word = 32'd0;
        repeat (3) @(negedge clk);
        check("R1 valid at reset", {31'd0, load_valid}, 32'd0);
        check("R1 flag at reset", {31'd0, load_misaligned}, 32'd0);
        rst_n = 1'b1;

        // R9: beat with nothing pending
        @(negedge clk); mem_valid = 1'b1; mem_word = 32'hDEAD_BEEF;
        @(negedge clk); idle_inputs();
        check("R9 idle beat", {31'd0, load_valid}, 32'd0);

        // exhaustive sweep of size, offset and sign over several words
        for (int wi = 0; wi < 4; wi++)
            for (int sz = 0; sz < 4; sz++)
                for (int off = 0; off < 4; off++)
                    for (int sg = 0; sg < 2; sg++)
                        one_load(2'(sz), 2'(off), 1'(sg), words[wi]);

        // R10: new request coinciding with the previous beat
        @(negedge clk); drive_req(2'd0, 2'd3, 1'b1);
        @(negedge clk); drive_req(2'd1, 2'd2, 1'b0); mem_valid = 1'b1; mem_word = 32'h80FF_7F00;
        @(negedge clk); req_valid = 1'b0; mem_valid = 1'b1; mem_word = 32'hC3A5_0000;
        check("R10 first beat", load_value, 32'hFFFF_FF80);
        check("R10 first valid", {31'd0, load_valid}, 32'd1);
        @(negedge clk); idle_inputs();
        check("R10 second beat", load_value, 32'h0000_C3A5);
        check("R10 second valid", {31'd0, load_valid}, 32'd1);
        @(negedge clk);
        check("R9 after pair", {31'd0, load_valid}, 32'd0);

        // R11: later request replaces an unserved one
        @(negedge clk); drive_req(2'd2, 2'd0, 1'b0);
        @(negedge clk); drive_req(2'd0, 2'd1, 1'b0);
        @(negedge clk); req_valid = 1'b0; mem_valid = 1'b1; mem_word = 32'h1122_9944;
        @(negedge clk); idle_inputs();
        check("R11 latest wins", load_value, 32'h0000_0099);

        // R8: result lasts exactly one cycle
        @(negedge clk);
        check("R8 single pulse", {31'd0, load_valid}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule